// File: doc/BRIEF.md
# Serial Flash Image Writer and Checker

This controller writes an image held in a local byte memory into a serial flash device and then confirms it. It has no direct flash pins. Every flash action goes out as a command to an external command sequencer. A command carries an operation, a flash address and a byte length, and the sequencer signals completion with a one-cycle acknowledge. Program data is pushed into the sequencer's transmit buffer ahead of the program command. Read data comes back as a byte stream while the read command runs.

A single start pulse in combined mode runs the whole job. The controller erases the target range, programs the image in chunks sized for the transmit buffer and the flash page, and then reads the range back and compares it byte by byte with the image. It reports pass, or fail together with the flash address of the first byte that differs. Three standalone modes run only a read, only a program or only an erase. The range for any mode is given as a start address plus either a byte count or an inclusive end address. The controller does not poll the flash for busy status. After each erase or program it waits a fixed number of cycles, set by a parameter.

Top module: `fpv_ctrl`

## Requirements
- R1: With `mode`=0 (combined), one `start` in idle issues, in order: one erase command (`seq_op`=1), program commands (`seq_op`=2) covering the whole range in ascending address order, and then read commands (`seq_op`=3) over the same range. When every compared byte matched, the run ends with `done` and `pass`=1.
- R2: Every program or read command has a length from 1 to `DEPTH` and does not cross a `PAGE`-byte boundary. Each chunk is the smallest of the bytes remaining, `DEPTH`, and the distance to the next page boundary, so a misaligned first chunk is shortened.
- R3: During verification, each returned byte for flash address A is compared with image byte at offset A − start. `img_addr` carries that offset, and `img_data` is expected one cycle later.
- R4: At the first mismatch, `fail` rises, `pass` stays 0 and `fail_addr` holds the failing flash address. No further read command is issued. `fail` and `fail_addr` stay stable until the next accepted `start`.
- R5: After the acknowledge of an erase or program command, `seq_req` stays low for at least `WAIT_CYC`+1 cycles before the next command.
- R6: With `range_is_end`=1, the length is `range_val` − `start_addr` + 1. If `range_val` < `start_addr`, the run issues no command and ends with `done`, `range_err`=1 and `pass`=0.
- R7: With `mode`=1 (read only) and `range_is_end`=0, the controller issues only read commands over `range_val` bytes. It presents each returned byte on `rd_valid`/`rd_addr`/`rd_data` with its flash address, in order.
- R8: With `mode`=2 (program only), the controller issues program commands only. The image byte at offset k lands at flash address start + k.
- R9: With `mode`=3 (erase only), the controller issues exactly one erase command with `seq_addr` = start and `seq_len` = the range length, waits, and ends with `pass`=1.
- R10: `done` is a single-cycle pulse. `pass` and `fail` are never both high. A zero byte count ends at once with `done` and `pass`=1 and issues no command.
- R11: A request holds `seq_op`, `seq_addr` and `seq_len` stable until `seq_ack`. Before a program request rises, exactly `seq_len` bytes are pushed in image order, and no byte is pushed while a request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mode | input | 2 | 0 combined, 1 read, 2 program, 3 erase |
| start_addr | input | ADDR_W | First flash address of the range |
| range_val | input | ADDR_W | Byte count, or inclusive end address |
| range_is_end | input | 1 | 1: `range_val` is an end address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run finished without mismatch or range error |
| fail | output | 1 | Verification mismatch seen |
| fail_addr | output | ADDR_W | Flash address of first mismatch |
| range_err | output | 1 | End address below start |
| img_addr | output | ADDR_W | Image memory byte offset |
| img_data | input | 8 | Image byte, one cycle after `img_addr` |
| seq_req | output | 1 | Command request, held until acknowledge |
| seq_op | output | 2 | 1 erase, 2 program, 3 read |
| seq_addr | output | ADDR_W | Command flash address |
| seq_len | output | ADDR_W+1 | Command byte length |
| seq_ack | input | 1 | Command complete |
| seq_tx_push | output | 1 | Push byte into sequencer transmit buffer |
| seq_tx_data | output | 8 | Byte pushed |
| seq_rx_valid | input | 1 | Returned read byte valid |
| seq_rx_data | input | 8 | Returned read byte |
| rd_valid | output | 1 | Read byte presented |
| rd_addr | output | ADDR_W | Flash address of presented byte |
| rd_data | output | 8 | Presented byte |

## Verification
Two events can land in the same cycle: the last returned byte of a read chunk and that chunk's acknowledge. That cycle both starts a compare and advances to the chunk decision. The bench's sequencer model raises the acknowledge together with the final byte of every read. It also corrupts the flash at the last byte of a mid-image chunk. The run must then stop after that chunk with `fail_addr` at that byte and no later read command, which the scoreboard judges from the ordered command list and the final result.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_READ  = 2'd1,
        MODE_PROG  = 2'd2,
        MODE_ERASE = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ERASE, S_EWAIT, S_PLAN, S_FILL,
        S_PROG, S_PWAIT, S_READ, S_RCHK, S_FINISH
    } state_e;

    typedef enum logic [1:0] {
        PH_PROG, PH_VERIFY, PH_READ
    } phase_e;

    // chunk = min(remaining, buffer depth, bytes left in page)
    function automatic int unsigned pick_chunk(int unsigned page_off,
                                               int unsigned remain,
                                               int unsigned depth,
                                               int unsigned page);
        int unsigned c;
        c = remain;
        if (c > depth) c = depth;
        if (c > page - page_off) c = page - page_off;
        return c;
    endfunction

endpackage

// File: rtl/fpv_range.sv
module fpv_range #(
    parameter int ADDR_W = 24,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] range_val,
    input  logic              range_is_end,
    output logic [LEN_W-1:0]  req_len,
    output logic              req_bad
);
    always_comb begin
        if (range_is_end) begin
            req_bad = (range_val < start_addr);
            req_len = {1'b0, range_val} - {1'b0, start_addr} + LEN_W'(1);
        end else begin
            req_bad = 1'b0;
            req_len = {1'b0, range_val};
        end
    end
endmodule

// File: rtl/fpv_wait_timer.sv
module fpv_wait_timer #(
    parameter int WAIT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (load)           cnt <= CW'(WAIT_CYC - 1);
        else if (run && cnt != '0) cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

    // R5: a freshly loaded wait is never reported as finished the next cycle
    assert_wait_armed_R5: assert property (@(posedge clk) disable iff (rst)
        (load && WAIT_CYC > 1) |=> !expired);
endmodule

// File: rtl/fpv_verify.sv
module fpv_verify #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [7:0]        flash_byte,
    input  logic [7:0]        image_byte,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (en && !fail && flash_byte != image_byte) begin
            fail      <= 1'b1;
            fail_addr <= byte_addr;
        end
    end

    // R4: once a mismatch is latched it stays, with a frozen address
    assert_fail_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> (fail && $stable(fail_addr)));
endmodule

// File: rtl/fpv_ctrl.sv
module fpv_ctrl
    import fpv_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DEPTH    = 16,
    parameter int PAGE     = 256,
    parameter int WAIT_CYC = 64,
    localparam int LEN_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] range_val,
    input  logic              range_is_end,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              range_err,
    output logic [ADDR_W-1:0] img_addr,
    input  logic [7:0]        img_data,
    output logic              seq_req,
    output logic [1:0]        seq_op,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [LEN_W-1:0]  seq_len,
    input  logic              seq_ack,
    output logic              seq_tx_push,
    output logic [7:0]        seq_tx_data,
    input  logic              seq_rx_valid,
    input  logic [7:0]        seq_rx_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    state_e             state;
    phase_e             phase;
    mode_e              mode_q;
    logic [ADDR_W-1:0]  start_q, cur, off;
    logic [LEN_W-1:0]   len_q, remain, chunk, idx, next_chunk, req_len;
    logic               req_bad, push_v, done_q, pass_q, err_q, expired;

    fpv_range #(.ADDR_W(ADDR_W)) u_range (
        .start_addr(start_addr), .range_val(range_val), .range_is_end(range_is_end),
        .req_len(req_len), .req_bad(req_bad)
    );

    fpv_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk(clk), .rst(rst),
        .load((state == S_ERASE || state == S_PROG) && seq_ack),
        .run(state == S_EWAIT || state == S_PWAIT),
        .expired(expired)
    );

    fpv_verify #(.ADDR_W(ADDR_W)) u_cmp (
        .clk(clk), .rst(rst),
        .clear(start && state == S_IDLE),
        .en(rd_valid && phase == PH_VERIFY),
        .flash_byte(rd_data), .image_byte(img_data), .byte_addr(rd_addr),
        .fail(fail), .fail_addr(fail_addr)
    );

    assign next_chunk = LEN_W'(pick_chunk(32'(cur) % 32'(PAGE), 32'(remain),
                                          32'(DEPTH), 32'(PAGE)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;  phase <= PH_PROG;  mode_q <= MODE_FULL;
            start_q <= '0;    cur <= '0;         off <= '0;
            len_q <= '0;      remain <= '0;      chunk <= '0;  idx <= '0;
            push_v <= 1'b0;   rd_valid <= 1'b0;  rd_addr <= '0; rd_data <= '0;
            done_q <= 1'b0;   pass_q <= 1'b0;    err_q <= 1'b0;
        end else begin
            push_v   <= 1'b0;
            rd_valid <= 1'b0;
            done_q   <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    mode_q  <= mode_e'(mode);
                    start_q <= start_addr;  cur <= start_addr;  off <= '0;
                    len_q   <= req_len;     remain <= req_len;
                    pass_q  <= 1'b0;        err_q <= req_bad;
                    if (req_bad || req_len == '0) state <= S_FINISH;
                    else begin
                        case (mode_e'(mode))
                            MODE_FULL, MODE_ERASE: state <= S_ERASE;
                            MODE_PROG: begin phase <= PH_PROG; state <= S_PLAN; end
                            default:   begin phase <= PH_READ; state <= S_PLAN; end
                        endcase
                    end
                end
                S_ERASE: if (seq_ack) state <= S_EWAIT;
                S_EWAIT: if (expired) begin
                    if (mode_q == MODE_ERASE) state <= S_FINISH;
                    else begin phase <= PH_PROG; state <= S_PLAN; end
                end
                S_PLAN: begin
                    if (phase == PH_VERIFY && fail) state <= S_FINISH;
                    else if (remain == '0) begin
                        if (phase == PH_PROG && mode_q == MODE_FULL) begin
                            phase <= PH_VERIFY;  cur <= start_q;
                            remain <= len_q;     off <= '0;
                        end else state <= S_FINISH;
                    end else begin
                        chunk <= next_chunk;
                        idx   <= '0;
                        state <= (phase == PH_PROG) ? S_FILL : S_READ;
                    end
                end
                S_FILL: begin
                    if (idx < chunk) begin
                        idx    <= idx + LEN_W'(1);
                        push_v <= 1'b1;
                    end else if (!push_v) state <= S_PROG;
                end
                S_PROG: if (seq_ack) begin
                    cur <= cur + chunk[ADDR_W-1:0];
                    off <= off + chunk[ADDR_W-1:0];
                    remain <= remain - chunk;
                    state <= S_PWAIT;
                end
                S_PWAIT: if (expired) state <= S_PLAN;
                S_READ: begin
                    if (seq_rx_valid) begin
                        idx      <= idx + LEN_W'(1);
                        rd_valid <= 1'b1;
                        rd_addr  <= cur + idx[ADDR_W-1:0];
                        rd_data  <= seq_rx_data;
                    end
                    if (seq_ack) begin
                        cur <= cur + chunk[ADDR_W-1:0];
                        off <= off + chunk[ADDR_W-1:0];
                        remain <= remain - chunk;
                        state <= S_RCHK;
                    end
                end
                S_RCHK: state <= S_PLAN;
                S_FINISH: begin
                    done_q <= 1'b1;
                    pass_q <= !err_q && !fail;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        seq_req  = (state == S_ERASE) || (state == S_PROG) || (state == S_READ);
        seq_op   = OP_NONE;
        seq_addr = cur;
        seq_len  = chunk;
        case (state)
            S_ERASE: begin seq_op = OP_ERASE; seq_addr = start_q; seq_len = len_q; end
            S_PROG:  seq_op = OP_PROG;
            S_READ:  seq_op = OP_READ;
            default: seq_op = OP_NONE;
        endcase
    end

    assign img_addr    = off + idx[ADDR_W-1:0];
    assign seq_tx_push = push_v;
    assign seq_tx_data = img_data;
    assign busy        = (state != S_IDLE);
    assign done        = done_q;
    assign pass        = pass_q;
    assign range_err   = err_q;

    // R10: end-of-run strobe lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10: success and mismatch are exclusive
    assert_pass_fail_R10: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));
    // R11: command fields frozen until acknowledged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (seq_req && !seq_ack) |=> (seq_req && $stable(seq_op)
                                   && $stable(seq_addr) && $stable(seq_len)));
    // R11: buffer fill never overlaps an open command
    assert_push_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        seq_tx_push |-> !seq_req);
    // R2: data commands fit the buffer and one page
    assert_chunk_fit_R2: assert property (@(posedge clk) disable iff (rst)
        (seq_req && seq_op != OP_ERASE) |->
        (seq_len != '0 && 32'(seq_len) <= DEPTH
         && (32'(seq_addr) % 32'(PAGE)) + 32'(seq_len) <= 32'(PAGE)));
    // R6: a rejected range issues nothing
    assert_no_cmd_on_err_R6: assert property (@(posedge clk) disable iff (rst)
        range_err |-> !seq_req);
endmodule

// File: tb/sim_fpv_ctrl.sv
module sim_fpv_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 24;
    localparam int LW    = AW + 1;
    localparam int DEP   = 16;
    localparam int PG    = 256;
    localparam int WAITC = 6;

    typedef struct {
        int kind;   // 0 command, 1 read byte, 2 end of run
        int a;
        int b;
        int c;
        int d;
    } item_t;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, range_is_end = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [AW-1:0] start_addr = '0, range_val = '0;
    logic busy, done, pass, fail, range_err;
    logic [AW-1:0] fail_addr, img_addr, seq_addr, rd_addr;
    logic [7:0] img_data, seq_tx_data, rd_data;
    logic seq_req, seq_tx_push, rd_valid;
    logic [1:0] seq_op;
    logic [LW-1:0] seq_len;
    logic seq_ack, seq_rx_valid;
    logic [7:0] seq_rx_data;

    logic [7:0] flash [0:4095];
    logic [7:0] img   [0:1023];
    item_t exp_q[$];
    logic [7:0] txq[$];
    int n_chk = 0, n_bad = 0;
    int done_cnt = 0;
    int corrupt = -1;
    bit chk_rd = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) img_data <= img[img_addr[9:0]];

    fpv_ctrl #(.ADDR_W(AW), .DEPTH(DEP), .PAGE(PG), .WAIT_CYC(WAITC)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .start_addr(start_addr),
        .range_val(range_val), .range_is_end(range_is_end), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .fail_addr(fail_addr), .range_err(range_err),
        .img_addr(img_addr), .img_data(img_data), .seq_req(seq_req), .seq_op(seq_op),
        .seq_addr(seq_addr), .seq_len(seq_len), .seq_ack(seq_ack),
        .seq_tx_push(seq_tx_push), .seq_tx_data(seq_tx_data),
        .seq_rx_valid(seq_rx_valid), .seq_rx_data(seq_rx_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bchunk(int a, int r);
        int c;
        c = r;
        if (c > DEP) c = DEP;
        if (c > PG - (a % PG)) c = PG - (a % PG);
        return c;
    endfunction

    // Sequencer and flash model: last read byte arrives with the acknowledge
    initial begin
        int op, a, n;
        logic [7:0] d;
        seq_ack = 1'b0; seq_rx_valid = 1'b0; seq_rx_data = 8'h00;
        for (int i = 0; i < 4096; i++) flash[i] = 8'((i * 13 + 5) & 255);
        forever begin
            @(negedge clk);
            if (!rst && seq_req) begin
                op = int'(seq_op); a = int'(seq_addr); n = int'(seq_len);
                repeat (2) @(negedge clk);
                if (op == 3) begin
                    for (int i = 0; i < n; i++) begin
                        seq_rx_valid = 1'b1;
                        seq_rx_data  = flash[(a + i) & 4095];
                        seq_ack      = (i == n - 1);
                        @(negedge clk);
                    end
                    seq_rx_valid = 1'b0;
                    seq_ack      = 1'b0;
                end else begin
                    for (int i = 0; i < n; i++) begin
                        if (op == 1) flash[(a + i) & 4095] = 8'hFF;
                        else begin
                            d = (txq.size() != 0) ? txq.pop_front() : 8'h00;
                            flash[(a + i) & 4095] = ((a + i) == corrupt) ? (d ^ 8'h5A) : d;
                        end
                    end
                    seq_ack = 1'b1;
                    @(negedge clk);
                    seq_ack = 1'b0;
                end
            end
        end
    end

    // Monitor: pops expected items as results appear
    initial begin
        bit req_open = 1'b0, gap_armed = 1'b0;
        int low_cnt = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (seq_tx_push) txq.push_back(seq_tx_data);
                if (seq_req && !req_open) begin
                    req_open = 1'b1;
                    if (gap_armed)
                        check(low_cnt >= WAITC + 1, "R5", "idle gap", low_cnt, WAITC + 1);
                    gap_armed = (seq_op == 2'd1 || seq_op == 2'd2);
                    if (exp_q.size() == 0) check(0, "R1", "unexpected command", int'(seq_op), 0);
                    else begin
                        it = exp_q.pop_front();
                        check(it.kind == 0, "R1", "command out of order", it.kind, 0);
                        check(int'(seq_op) == it.a, "R1", "seq_op", int'(seq_op), it.a);
                        check(int'(seq_addr) == it.b, "R2", "seq_addr", int'(seq_addr), it.b);
                        check(int'(seq_len) == it.c, "R2", "seq_len", int'(seq_len), it.c);
                        if (seq_op == 2'd2)
                            check(txq.size() == it.c, "R11", "bytes pushed", txq.size(), it.c);
                    end
                end
                if (!seq_req) begin
                    req_open = 1'b0;
                    low_cnt++;
                end else low_cnt = 0;
                if (rd_valid && chk_rd) begin
                    if (exp_q.size() == 0) check(0, "R7", "unexpected read byte", int'(rd_addr), 0);
                    else begin
                        it = exp_q.pop_front();
                        check(it.kind == 1 && int'(rd_addr) == it.a, "R7", "rd_addr", int'(rd_addr), it.a);
                        check(int'(rd_data) == it.b, "R7", "rd_data", int'(rd_data), it.b);
                    end
                end
                if (done) begin
                    gap_armed = 1'b0;
                    if (exp_q.size() == 0) check(0, "R10", "unexpected done", 1, 0);
                    else begin
                        it = exp_q.pop_front();
                        check(it.kind == 2, "R1", "done early", it.kind, 2);
                        check(int'(pass) == it.a, "R10", "pass", int'(pass), it.a);
                        check(int'(fail) == it.b, "R4", "fail", int'(fail), it.b);
                        check(int'(fail_addr) == it.c, "R4", "fail_addr", int'(fail_addr), it.c);
                        check(int'(range_err) == it.d, "R6", "range_err", int'(range_err), it.d);
                    end
                    done_cnt++;
                end
            end
        end
    end

    task automatic push_item(int k, int a, int b, int c, int d);
        item_t it;
        it.kind = k; it.a = a; it.b = b; it.c = c; it.d = d;
        exp_q.push_back(it);
    endtask

    // Driver: builds the expected trace, then launches the run
    task automatic run_op(int md, int sa, int rv, bit is_end, int bad);
        int len, a, r, c, d0;
        bit err, stop;
        err = is_end && (rv < sa);
        len = is_end ? (rv - sa + 1) : rv;
        chk_rd = (md == 1);
        if (!err && len != 0) begin
            if (md == 0 || md == 3) push_item(0, 1, sa, len, 0);
            if (md == 0 || md == 2) begin
                a = sa; r = len;
                while (r > 0) begin c = bchunk(a, r); push_item(0, 2, a, c, 0); a += c; r -= c; end
            end
            if (md == 0 || md == 1) begin
                a = sa; r = len; stop = 1'b0;
                while (r > 0 && !stop) begin
                    c = bchunk(a, r);
                    push_item(0, 3, a, c, 0);
                    if (md == 1)
                        for (int i = 0; i < c; i++) push_item(1, a + i, int'(flash[(a + i) & 4095]), 0, 0);
                    if (bad >= a && bad < a + c) stop = 1'b1;
                    a += c; r -= c;
                end
            end
        end
        if (err) push_item(2, 0, 0, 0, 1);
        else if (bad >= 0) push_item(2, 0, 1, bad, 0);
        else push_item(2, 1, 0, 0, 0);
        corrupt = bad;
        d0 = done_cnt;
        @(negedge clk);
        mode = 2'(md); start_addr = AW'(sa); range_val = AW'(rv); range_is_end = is_end;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1", "items left over", exp_q.size(), 0);
        exp_q.delete();
        corrupt = -1;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) img[i] = 8'((i * 37 + 11) & 255);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !seq_req && !pass && !fail && !range_err && !seq_tx_push,
              "R10", "reset state", {busy, done, seq_req, pass, fail}, 0);

        // R1 R2 R3: combined run across a page boundary
        run_op(0, 'h0F8, 40, 1'b0, -1);
        begin
            int bad_b = 0;
            for (int i = 0; i < 40; i++) if (flash['h0F8 + i] != img[i]) bad_b++;
            check(bad_b == 0, "R3", "flash holds image", bad_b, 0);
        end

        // R4: mismatch on the byte that arrives with the acknowledge
        run_op(0, 'h0F8, 40, 1'b0, 'h10F);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(fail && !pass && int'(fail_addr) == 'h10F, "R4", "fail held",
                  int'(fail_addr), 'h10F);
        end

        // R6 R7: read only, end-address form
        run_op(1, 'h0F4, 'h10A, 1'b1, -1);

        // R8: program only, end-address form across a page
        run_op(2, 'h1FE, 'h203, 1'b1, -1);
        begin
            int bad_b = 0;
            for (int i = 0; i < 6; i++) if (flash['h1FE + i] != img[i]) bad_b++;
            check(bad_b == 0, "R8", "programmed bytes", bad_b, 0);
        end

        // R9: erase only
        run_op(3, 'h300, 16, 1'b0, -1);

        // R6: end below start rejected
        run_op(0, 'h200, 'h1FF, 1'b1, -1);

        // R10: zero count
        run_op(0, 'h040, 0, 1'b0, -1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule